// File: doc/BRIEF.md
# Wide Bus Odd-Byte Residue Packer

This block turns a byte stream into 16-bit words for a wide peripheral bus. It works on one send command at a time. Each command gives a byte count and a chained flag. Bytes come in on a byte-wide valid/ready port, and words leave on a 16-bit valid/ready port. Within a word, the earlier byte is the low-order byte.

When a command ends on an odd byte, the chained flag decides what happens to that byte:
- **Chained:** the byte is not sent. It is kept in a residue latch and a readable residue flag goes high. The next send command, chained or not, treats its first byte as the high-order partner of the held byte. It emits the pair as its first word and clears the flag.
- **Not chained:** the lone byte goes out as a word whose upper half is zero.

A run of N wide sends therefore marks commands 1 to N-1 as chained, so that a straggling byte carries forward between them.

The controller is a five-state machine:
- `ST_IDLE`: waits for `cmd_start`. It goes to `ST_FILL_LO` (no residue), `ST_FILL_HI` (residue pending, whose byte is preloaded as the low half) or `ST_FINISH` (count of zero).
- `ST_FILL_LO`: takes a low byte. It goes to `ST_FILL_HI` when two or more bytes remain. On the last byte it goes to `ST_SEND` when not chained, or to `ST_FINISH` when chained, latching the residue.
- `ST_FILL_HI`: takes a high byte and goes to `ST_SEND`.
- `ST_SEND`: presents the word until it is accepted. It then goes to `ST_FILL_LO`, or to `ST_FINISH` when no bytes remain.
- `ST_FINISH`: raises `cmd_done` for one cycle and returns to `ST_IDLE`.

Top module: `wide_residue_packer`

## Requirements
- R1: Two consecutive bytes of a command leave as one word, with the earlier byte in bits 7:0 and the later byte in bits 15:8.
- R2: When a chained command ends on an odd byte, that byte is not sent. It is held and `residue_flag` reads 1.
- R3: When a non-chained command ends on an odd byte, that byte is sent as a word with the byte in bits 7:0 and 8'h00 in bits 15:8.
- R4: If `residue_flag` is 1 when a command with a count above zero starts, the first word carries the held byte in bits 7:0 and the command's first byte in bits 15:8. `residue_flag` then returns to 0. This holds whether or not the new command is chained.
- R5: `cmd_done` is a one-cycle pulse, given exactly once per command. It comes only after the last word has been accepted or the odd byte has been latched. A zero-count command completes with no words and leaves `residue_flag` unchanged.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged.
- R7: `cmd_start` is ignored from the cycle a command is accepted until that command's `cmd_done`.
- R8: Reset leaves `residue_flag`, `in_ready`, `out_valid` and `cmd_done` at 0 and discards any held byte.
- R9: A command takes exactly its byte count from the input; `in_ready` is never 1 when no bytes of the command remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start a send command (taken in idle only) |
| cmd_count | input | CNT_W | Bytes in the command |
| cmd_chain | input | 1 | Chained flag: hold a trailing odd byte |
| cmd_done | output | 1 | One-cycle completion pulse |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block takes a byte this cycle |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Output word, low byte in 7:0 |
| out_ready | input | 1 | Downstream takes the word |
| residue_flag | output | 1 | A held odd byte is pending |

## Verification
Two functions can fall together: consuming a held residue byte, and taking the final byte of a command. This happens when a residue is pending and the new command has a count of one, or when a chained count-two command consumes the residue and then latches a new one.

The bench provokes both cases from its vector table. It judges them by the exact word, by a single `cmd_done` that comes only after that word is accepted, and by the final `residue_flag`.

A second overlap is a `cmd_start` pulse raised while a stalled word is waiting on the output. It is judged by the unchanged word stream and by the single completion pulse.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_LO,
        ST_FILL_HI,
        ST_SEND,
        ST_FINISH
    } wrp_state_e;
endpackage

// File: rtl/wrp_countdown.sv
module wrp_countdown #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] remaining,
    output logic             is_last,
    output logic             is_empty
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n)
            remaining <= '0;
        else if (load)
            remaining <= load_val;
        else if (dec)
            remaining <= remaining - ONE;
    end

    assign is_last  = (remaining == ONE);
    assign is_empty = (remaining == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (remaining != '0)); // R9
endmodule

// File: rtl/wrp_residue_latch.sv
module wrp_residue_latch #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store,
    input  logic [BYTE_W-1:0] store_byte,
    input  logic              consume,
    output logic [BYTE_W-1:0] held_byte,
    output logic              held_flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_flag <= 1'b0;
            held_byte <= '0;
        end else if (store) begin
            held_flag <= 1'b1;
            held_byte <= store_byte;
        end else if (consume) begin
            held_flag <= 1'b0;
        end
    end

    AST_STORE_CONSUME_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(store && consume)); // R4
endmodule

// File: rtl/wrp_word_builder.sv
module wrp_word_builder #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic [BYTE_W-1:0] lo_d,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] hi_d,
    output logic [WORD_W-1:0] word
);
    logic [BYTE_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (lo_we) lo_q <= lo_d;
            if (hi_we) hi_q <= hi_d;
        end
    end

    assign word = {hi_q, lo_q};
endmodule

// File: rtl/wide_residue_packer.sv
module wide_residue_packer #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              cmd_chain,
    output logic              cmd_done,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    input  logic              out_ready,
    output logic              residue_flag
);
    import wrp_pkg::*;

    wrp_state_e state, state_nx;
    logic chain_q;

    logic              cnt_load, cnt_dec, cnt_last, cnt_empty;
    logic [CNT_W-1:0]  cnt_rem;
    logic              res_store, res_consume;
    logic [BYTE_W-1:0] res_byte;
    logic              lo_we, hi_we;
    logic [BYTE_W-1:0] lo_d, hi_d;
    logic              take, give, start_ok;

    assign take     = in_ready && in_valid;
    assign give     = out_valid && out_ready;
    assign start_ok = (state == ST_IDLE) && cmd_start;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            chain_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (start_ok) chain_q <= cmd_chain;
        end
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cmd_start) begin
                if (cmd_count == '0)   state_nx = ST_FINISH;
                else if (residue_flag) state_nx = ST_FILL_HI;
                else                   state_nx = ST_FILL_LO;
            end
            ST_FILL_LO: if (take) begin
                if (!cnt_last)    state_nx = ST_FILL_HI;
                else if (chain_q) state_nx = ST_FINISH;
                else              state_nx = ST_SEND;
            end
            ST_FILL_HI: if (take) state_nx = ST_SEND;
            ST_SEND: if (out_ready) state_nx = cnt_empty ? ST_FINISH : ST_FILL_LO;
            ST_FINISH: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs and datapath strobes
    always_comb begin
        in_ready    = (state == ST_FILL_LO) || (state == ST_FILL_HI);
        out_valid   = (state == ST_SEND);
        cmd_done    = (state == ST_FINISH);
        cnt_load    = start_ok;
        cnt_dec     = take;
        res_store   = take && (state == ST_FILL_LO) && cnt_last && chain_q;
        res_consume = take && (state == ST_FILL_HI) && residue_flag;
        lo_we       = 1'b0;
        lo_d        = in_data;
        hi_we       = 1'b0;
        hi_d        = in_data;
        if (start_ok && residue_flag) begin
            lo_we = 1'b1;
            lo_d  = res_byte;
        end
        if (take && state == ST_FILL_LO) begin
            lo_we = 1'b1;
            hi_we = 1'b1;
            hi_d  = '0;
        end
        if (take && state == ST_FILL_HI)
            hi_we = 1'b1;
    end

    wrp_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cmd_count),
        .dec(cnt_dec), .remaining(cnt_rem), .is_last(cnt_last), .is_empty(cnt_empty)
    );

    wrp_residue_latch #(.BYTE_W(BYTE_W)) u_res (
        .clk(clk), .rst_n(rst_n), .store(res_store), .store_byte(in_data),
        .consume(res_consume), .held_byte(res_byte), .held_flag(residue_flag)
    );

    wrp_word_builder #(.BYTE_W(BYTE_W)) u_word (
        .clk(clk), .rst_n(rst_n), .lo_we(lo_we), .lo_d(lo_d),
        .hi_we(hi_we), .hi_d(hi_d), .word(out_data)
    );

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done); // R5
    AST_FLAG_RISE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(residue_flag) |-> cmd_done); // R2
    AST_FLAG_FALL_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(residue_flag) |-> $past(in_valid && in_ready)); // R4
    AST_NO_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (cnt_rem != '0)); // R9
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && cmd_start && !out_ready) |=> out_valid); // R7
endmodule

// File: tb/wide_residue_packer_tb_top.sv
`timescale 1ns/1ps
module wide_residue_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [15:0] cmd_count = '0;
    logic        cmd_chain = 1'b0;
    logic        cmd_done;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_ready = 1'b0;
    logic        residue_flag;

    always #4 clk = ~clk;

    wide_residue_packer dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_count(cmd_count),
        .cmd_chain(cmd_chain), .cmd_done(cmd_done), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready), .residue_flag(residue_flag)
    );

    int checks = 0;
    int errors = 0;
    int src_idx = 0;
    int mdl_idx = 0;
    bit mdl_flag = 1'b0;
    logic [7:0] mdl_res = '0;
    logic [15:0] exp_w [0:15];
    logic [15:0] cap [0:15];
    int nexp, ncap, ndone, done_words;

    // vector: {count[7:0], out_ready pattern[7:0], exp words[3:0], 2'b0, chain, exp flag}
    localparam int NV = 10;
    localparam logic [23:0] VEC [NV] = '{
        {8'd5, 8'hFF, 4'd2, 2'b0, 1'b1, 1'b1},
        {8'd3, 8'hA5, 4'd2, 2'b0, 1'b0, 1'b0},
        {8'd4, 8'h6D, 4'd2, 2'b0, 1'b0, 1'b0},
        {8'd3, 8'hFF, 4'd2, 2'b0, 1'b0, 1'b0},
        {8'd1, 8'hFF, 4'd0, 2'b0, 1'b1, 1'b1},
        {8'd1, 8'h33, 4'd1, 2'b0, 1'b0, 1'b0},
        {8'd0, 8'hFF, 4'd0, 2'b0, 1'b0, 1'b0},
        {8'd7, 8'h81, 4'd3, 2'b0, 1'b1, 1'b1},
        {8'd2, 8'hFF, 4'd1, 2'b0, 1'b1, 1'b1},
        {8'd6, 8'h5A, 4'd4, 2'b0, 1'b0, 1'b0}
    };

    function automatic logic [7:0] byte_at(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference model of one command, from the requirements
    task automatic model_cmd(input int cnt, input bit chn);
        int rem = cnt;
        nexp = 0;
        if (rem > 0 && mdl_flag) begin
            exp_w[nexp] = {byte_at(mdl_idx), mdl_res}; nexp++;
            mdl_idx++; rem--; mdl_flag = 1'b0;
        end
        while (rem >= 2) begin
            exp_w[nexp] = {byte_at(mdl_idx + 1), byte_at(mdl_idx)}; nexp++;
            mdl_idx += 2; rem -= 2;
        end
        if (rem == 1) begin
            if (chn) begin
                mdl_res = byte_at(mdl_idx); mdl_flag = 1'b1;
            end else begin
                exp_w[nexp] = {8'h00, byte_at(mdl_idx)}; nexp++;
            end
            mdl_idx++;
        end
    endtask

    task automatic run_cmd(input int cnt, input bit chn, input logic [7:0] pat,
                           input bit poke, input string req);
        bit prev_stall = 1'b0;
        logic [15:0] prev_word = '0;
        int start_src = src_idx;
        int tail = -1;
        model_cmd(cnt, chn);
        ncap = 0; ndone = 0; done_words = -1;
        @(negedge clk);
        cmd_start = 1'b1; cmd_count = 16'(cnt); cmd_chain = chn;
        for (int c = 0; c < 300; c++) begin
            in_valid  = 1'b1;
            in_data   = byte_at(src_idx);
            out_ready = pat[c % 8];
            #1;
            if (prev_stall)
                check(out_valid && out_data == prev_word, "R6", "stalled word held",
                      int'(out_data), int'(prev_word));
            prev_stall = out_valid && !out_ready;
            prev_word  = out_data;
            if (in_valid && in_ready) src_idx++;
            if (out_valid && out_ready && ncap < 16) begin
                cap[ncap] = out_data; ncap++;
            end
            if (cmd_done) begin
                ndone++; done_words = ncap;
                if (tail < 0) tail = 3;
            end
            @(negedge clk);
            cmd_start = poke && (c == 2);
            cmd_count = poke ? 16'd1 : 16'(cnt);
            cmd_chain = poke ? 1'b1 : chn;
            if (tail > 0) tail--;
            if (tail == 0) break;
        end
        in_valid = 1'b0; out_ready = 1'b0; cmd_start = 1'b0;
        check(ncap == nexp, req, "word count", ncap, nexp);
        for (int i = 0; i < nexp && i < ncap; i++)
            check(cap[i] == exp_w[i], "R1 R3 R4", "word value", int'(cap[i]), int'(exp_w[i]));
        check(ndone == 1, "R5", "done pulses", ndone, 1);
        check(done_words == nexp, "R5", "words before done", done_words, nexp);
        check(residue_flag == mdl_flag, "R2 R4", "residue flag", int'(residue_flag), int'(mdl_flag));
        check(src_idx - start_src == cnt, "R9", "bytes taken", src_idx - start_src, cnt);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mdl_flag = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        #1;
        check(!residue_flag && !in_ready && !out_valid && !cmd_done, "R8", "reset outputs",
              {residue_flag, in_ready, out_valid, cmd_done}, 0);

        for (int v = 0; v < NV; v++) begin
            run_cmd(int'(VEC[v][23:16]), VEC[v][1], VEC[v][15:8], 1'b0, "R1 R2 R3");
            check(int'(VEC[v][7:4]) == nexp, "R1", "table word count", nexp, int'(VEC[v][7:4]));
            check(residue_flag == VEC[v][0], "R2 R4", "table flag",
                  int'(residue_flag), int'(VEC[v][0]));
        end

        // R7: start pulse while a word stalls on the output is ignored
        run_cmd(4, 1'b0, 8'hF0, 1'b1, "R7");
        #1;
        check(!out_valid && !in_ready, "R7", "idle after poked command",
              {out_valid, in_ready}, 0);

        // R5: zero-count command keeps a pending residue
        run_cmd(3, 1'b1, 8'hFF, 1'b0, "R2");
        run_cmd(0, 1'b0, 8'hFF, 1'b0, "R5");
        check(residue_flag == 1'b1, "R5", "flag kept by zero count", int'(residue_flag), 1);

        // R8: reset discards the held byte
        do_reset();
        #1;
        check(residue_flag == 1'b0, "R8", "flag after reset", int'(residue_flag), 0);
        run_cmd(2, 1'b0, 8'hFF, 1'b0, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule